// File: doc/BRIEF.md
# Dual-Host Interrupt Cause Controller

This block keeps one word of sticky interrupt causes that two hosts share: a processor-side register port and a PCI-side register port. Single-cycle pulses from event sources (address-range violations, DMA completions, timer expirations, parity errors, bus aborts, retry expiry) set cause bits. Either host clears an event cause by writing a 0 to its bit position. Writing 1 leaves a bit alone.

Two groups of doorbell bits let each host interrupt the other. The sender rings a doorbell by writing 0 to its bit. Only the receiver can clear it, also by writing 0. Each host has its own mask register. The block drives one interrupt output per host. Each output covers a different subset of the cause bits, gated by that host's mask. An unmasked summary of every cause bit is read back in bit 0.

With default parameters the cause word has this layout:
- bit 0: global summary
- bits 20:1: events
- bits 25:21: processor-to-PCI doorbells
- bits 29:26: PCI-to-processor doorbells
- bit 30: processor interrupt summary
- bit 31: PCI interrupt summary

Top module: `irq_cause_hub`

## Requirements
- R1: After a synchronous reset, the cause bits and both mask registers are 0, and both interrupt outputs are low.
- R2: A pulse on `evt_pulse[i]` sets cause bit i+1 at the next clock edge. The bit stays set until it is cleared.
- R3: A write to the cause register (word offset 0) from either host clears every event bit written as 0. Event bits written as 1 keep their value. An event bit never rises without its pulse.
- R4: Bits 25:21 are processor-to-PCI doorbells. A processor write of 0 sets the bit, and a PCI write of 0 clears it. A PCI write of 0 to a clear doorbell bit leaves it clear.
- R5: Bits 29:26 are PCI-to-processor doorbells. A PCI write of 0 sets the bit, and a processor write of 0 clears it. A processor write of 0 to a clear doorbell bit leaves it clear.
- R6: If an event pulse and a clearing write reach the same bit in the same cycle, the bit ends set.
- R7: Read bit 0 is the OR of cause bits 29:1, independent of both masks.
- R8: `cpu_irq` and read bit 30 are the OR of cause bits 20:1 and 29:26, each ANDed with the same bit of the processor mask. The processor-to-PCI doorbells never drive `cpu_irq`.
- R9: `pci_irq` and read bit 31 are the OR of cause bits 25:1, each ANDed with the same bit of the PCI mask. The PCI-to-processor doorbells never drive `pci_irq`.
- R10: Each host reads and writes its own mask at word offset 1. Mask bits 29:1 are stored. Mask bits 0, 30 and 31 read as 0. A write from one host never changes the other host's mask.
- R11: Writes to cause bits 0, 30 and 31 have no effect; those bits are always computed.
- R12: If both hosts write the cause register in the same cycle, each bit takes the combined effect of both writes. When one write sets a doorbell bit and the other clears it, the bit ends set.
- R13: A host reads its registers only while its select is high; otherwise its read data is 0. Word offsets 2 and 3 read as 0, and writes to them are ignored, as are writes with select low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_sel | input | 1 | Processor port select |
| cpu_wr | input | 1 | Processor write strobe (read when low) |
| cpu_addr | input | 2 | Processor word offset |
| cpu_wdata | input | 32 | Processor write data |
| cpu_rdata | output | 32 | Processor read data |
| pci_sel | input | 1 | PCI port select |
| pci_wr | input | 1 | PCI write strobe (read when low) |
| pci_addr | input | 2 | PCI word offset |
| pci_wdata | input | 32 | PCI write data |
| pci_rdata | output | 32 | PCI read data |
| evt_pulse | input | 20 | One-cycle event pulses; bit i sets cause bit i+1 |
| cpu_irq | output | 1 | Interrupt to the processor, active high |
| pci_irq | output | 1 | Interrupt to the PCI side, active high |

## Verification
The bench builds the block with its default parameters:
- 20 event bits
- 5 processor-to-PCI doorbells
- 4 PCI-to-processor doorbells
- a 2-bit word offset

These values give the full 32-bit cause word, so every field boundary is reached with literal data words:
- the event/doorbell edge at bits 20 and 21
- the doorbell/doorbell edge at bits 25 and 26
- the three computed bits

With these values the bench can also show that each interrupt output ignores the doorbell group aimed at the other side, even when that host's mask bit is set. The two offsets with no register are reachable as well.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;

    // Word offsets inside each host's register window.
    localparam int OFS_CAUSE = 0;
    localparam int OFS_MASK  = 1;

    // Kind of access a host port is making this cycle.
    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_CAUSE = 2'd1,
        ACC_MASK  = 2'd2
    } acc_kind_e;

endpackage

// File: rtl/irq_host_port.sv
module irq_host_port
    import irq_cause_pkg::*;
#(
    parameter int W      = 32,
    parameter int ADDR_W = 2,
    localparam int MW    = W - 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    input  logic [W-1:0]      cause_word,
    output logic [W-1:0]      rdata,
    output logic [MW-1:0]     mask_q,
    output logic [MW-1:0]     zero_vec
);

    acc_kind_e kind;
    logic      unused_wbits;

    // Data bits that no register stores.
    assign unused_wbits = ^{wdata[0], wdata[W-1:W-2]};

    always_comb begin
        kind = ACC_NONE;
        if (sel && (addr == ADDR_W'(OFS_CAUSE))) kind = ACC_CAUSE;
        if (sel && (addr == ADDR_W'(OFS_MASK)))  kind = ACC_MASK;
    end

    // Mask register: only the bits that gate a cause bit are stored.
    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (wr && (kind == ACC_MASK)) begin
            mask_q <= wdata[W-3:1];
        end
    end

    // Bits this host wrote as zero into the cause register.
    always_comb begin
        zero_vec = '0;
        if (wr && (kind == ACC_CAUSE)) zero_vec = ~wdata[W-3:1];
    end

    always_comb begin
        rdata = '0;
        unique case (kind)
            ACC_CAUSE: rdata = cause_word;
            ACC_MASK:  rdata = {2'b00, mask_q, 1'b0};
            default:   rdata = '0;
        endcase
    end

    // R10: mask changes only on a mask write from this host
    p_mask_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !(wr && (kind == ACC_MASK)) |=> $stable(mask_q));

    // R13: an unselected port never reports a cause write
    p_no_sel_write_r13: assert property (@(posedge clk) disable iff (rst)
        !sel |-> (zero_vec == '0));

endmodule

// File: rtl/irq_cause_store.sv
module irq_cause_store #(
    parameter int NUM_EVT = 20,
    parameter int CPU_DB  = 5,
    parameter int PCI_DB  = 4,
    localparam int MW     = NUM_EVT + CPU_DB + PCI_DB
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EVT-1:0] evt_pulse,
    input  logic [MW-1:0]      cpu_zero,
    input  logic [MW-1:0]      pci_zero,
    output logic [MW-1:0]      cause_q
);

    localparam int CDB_LO = NUM_EVT;
    localparam int CDB_HI = NUM_EVT + CPU_DB - 1;
    localparam int PDB_LO = NUM_EVT + CPU_DB;
    localparam int PDB_HI = MW - 1;

    logic [MW-1:0] cause_d;

    for (genvar i = 0; i < MW; i++) begin : g_bit
        if (i < NUM_EVT) begin : g_evt
            // Event: a pulse sets the bit; a zero from either host clears it.
            assign cause_d[i] = evt_pulse[i] | (cause_q[i] & ~cpu_zero[i] & ~pci_zero[i]);
        end else if (i <= CDB_HI) begin : g_cdb
            // Processor-to-PCI doorbell: processor sets it, PCI clears it.
            assign cause_d[i] = cpu_zero[i] | (cause_q[i] & ~pci_zero[i]);
        end else begin : g_pdb
            // PCI-to-processor doorbell: PCI sets it, processor clears it.
            assign cause_d[i] = pci_zero[i] | (cause_q[i] & ~cpu_zero[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cause_q <= '0;
        else     cause_q <= cause_d;
    end

    // R1: reset empties the cause bits
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (cause_q == '0));

    // R2: every pulsed event is held on the next cycle
    p_evt_set_r2: assert property (@(posedge clk) disable iff (rst)
        (evt_pulse != '0) |=>
        ((cause_q[NUM_EVT-1:0] & $past(evt_pulse)) == $past(evt_pulse)));

    // R3: without a pulse no event bit rises
    p_no_spurious_r3: assert property (@(posedge clk) disable iff (rst)
        (evt_pulse == '0) |=>
        ((cause_q[NUM_EVT-1:0] & ~$past(cause_q[NUM_EVT-1:0])) == '0));

    // R4: processor doorbells rise only on a processor zero write
    p_cdb_src_r4: assert property (@(posedge clk) disable iff (rst)
        (cpu_zero[CDB_HI:CDB_LO] == '0) |=>
        ((cause_q[CDB_HI:CDB_LO] & ~$past(cause_q[CDB_HI:CDB_LO])) == '0));

    // R4: a PCI zero write alone clears a processor doorbell
    p_cdb_clr_r4: assert property (@(posedge clk) disable iff (rst)
        ((pci_zero[CDB_HI:CDB_LO] != '0) && (cpu_zero[CDB_HI:CDB_LO] == '0)) |=>
        ((cause_q[CDB_HI:CDB_LO] & $past(pci_zero[CDB_HI:CDB_LO])) == '0));

    // R5: PCI doorbells rise only on a PCI zero write
    p_pdb_src_r5: assert property (@(posedge clk) disable iff (rst)
        (pci_zero[PDB_HI:PDB_LO] == '0) |=>
        ((cause_q[PDB_HI:PDB_LO] & ~$past(cause_q[PDB_HI:PDB_LO])) == '0));

    // R6: a pulse beats a clear on the same bit
    p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
        ((evt_pulse & (cpu_zero[NUM_EVT-1:0] | pci_zero[NUM_EVT-1:0])) != '0) |=>
        ((cause_q[NUM_EVT-1:0] & $past(evt_pulse & (cpu_zero[NUM_EVT-1:0] | pci_zero[NUM_EVT-1:0])))
          == $past(evt_pulse & (cpu_zero[NUM_EVT-1:0] | pci_zero[NUM_EVT-1:0]))));

endmodule

// File: rtl/irq_summary.sv
module irq_summary #(
    parameter int NUM_EVT = 20,
    parameter int CPU_DB  = 5,
    parameter int PCI_DB  = 4,
    localparam int MW     = NUM_EVT + CPU_DB + PCI_DB
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [MW-1:0] cause_q,
    input  logic [MW-1:0] cpu_mask,
    input  logic [MW-1:0] pci_mask,
    output logic          glob_sum,
    output logic          cpu_irq,
    output logic          pci_irq
);

    // Which cause bits each host's interrupt may see.
    localparam logic [MW-1:0] CPU_SCOPE =
        {{PCI_DB{1'b1}}, {CPU_DB{1'b0}}, {NUM_EVT{1'b1}}};
    localparam logic [MW-1:0] PCI_SCOPE =
        {{PCI_DB{1'b0}}, {CPU_DB{1'b1}}, {NUM_EVT{1'b1}}};

    assign glob_sum = |cause_q;
    assign cpu_irq  = |(cause_q & cpu_mask & CPU_SCOPE);
    assign pci_irq  = |(cause_q & pci_mask & PCI_SCOPE);

    // R7: any masked interrupt implies the unmasked summary
    p_glob_cover_r7: assert property (@(posedge clk) disable iff (rst)
        (cpu_irq || pci_irq) |-> glob_sum);

    // R8: a fully masked processor side stays quiet
    p_cpu_masked_r8: assert property (@(posedge clk) disable iff (rst)
        (cpu_mask == '0) |-> !cpu_irq);

    // R9: a fully masked PCI side stays quiet
    p_pci_masked_r9: assert property (@(posedge clk) disable iff (rst)
        (pci_mask == '0) |-> !pci_irq);

endmodule

// File: rtl/irq_cause_hub.sv
module irq_cause_hub #(
    parameter int NUM_EVT = 20,
    parameter int CPU_DB  = 5,
    parameter int PCI_DB  = 4,
    parameter int ADDR_W  = 2,
    localparam int MW     = NUM_EVT + CPU_DB + PCI_DB,
    localparam int W      = MW + 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cpu_sel,
    input  logic               cpu_wr,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [W-1:0]       cpu_wdata,
    output logic [W-1:0]       cpu_rdata,
    input  logic               pci_sel,
    input  logic               pci_wr,
    input  logic [ADDR_W-1:0]  pci_addr,
    input  logic [W-1:0]       pci_wdata,
    output logic [W-1:0]       pci_rdata,
    input  logic [NUM_EVT-1:0] evt_pulse,
    output logic               cpu_irq,
    output logic               pci_irq
);

    logic [MW-1:0] cause_q;
    logic [MW-1:0] cpu_mask, pci_mask;
    logic [MW-1:0] cpu_zero, pci_zero;
    logic [W-1:0]  cause_word;
    logic          glob_sum;

    assign cause_word = {pci_irq, cpu_irq, cause_q, glob_sum};

    irq_host_port #(.W(W), .ADDR_W(ADDR_W)) u_cpu_port (
        .clk        (clk),
        .rst        (rst),
        .sel        (cpu_sel),
        .wr         (cpu_wr),
        .addr       (cpu_addr),
        .wdata      (cpu_wdata),
        .cause_word (cause_word),
        .rdata      (cpu_rdata),
        .mask_q     (cpu_mask),
        .zero_vec   (cpu_zero)
    );

    irq_host_port #(.W(W), .ADDR_W(ADDR_W)) u_pci_port (
        .clk        (clk),
        .rst        (rst),
        .sel        (pci_sel),
        .wr         (pci_wr),
        .addr       (pci_addr),
        .wdata      (pci_wdata),
        .cause_word (cause_word),
        .rdata      (pci_rdata),
        .mask_q     (pci_mask),
        .zero_vec   (pci_zero)
    );

    irq_cause_store #(.NUM_EVT(NUM_EVT), .CPU_DB(CPU_DB), .PCI_DB(PCI_DB)) u_store (
        .clk       (clk),
        .rst       (rst),
        .evt_pulse (evt_pulse),
        .cpu_zero  (cpu_zero),
        .pci_zero  (pci_zero),
        .cause_q   (cause_q)
    );

    irq_summary #(.NUM_EVT(NUM_EVT), .CPU_DB(CPU_DB), .PCI_DB(PCI_DB)) u_sum (
        .clk      (clk),
        .rst      (rst),
        .cause_q  (cause_q),
        .cpu_mask (cpu_mask),
        .pci_mask (pci_mask),
        .glob_sum (glob_sum),
        .cpu_irq  (cpu_irq),
        .pci_irq  (pci_irq)
    );

    // R1: both outputs are low right after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!cpu_irq && !pci_irq));

    // R11: the computed top bits never both appear without cause bits
    p_top_bits_r11: assert property (@(posedge clk) disable iff (rst)
        (cause_q == '0) |-> (!cpu_irq && !pci_irq && !glob_sum));

endmodule

// File: tb/tb_irq_cause_hub.sv
module tb_irq_cause_hub;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_sel = 1'b0, cpu_wr = 1'b0;
    logic [1:0]  cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        pci_sel = 1'b0, pci_wr = 1'b0;
    logic [1:0]  pci_addr = '0;
    logic [31:0] pci_wdata = '0;
    logic [31:0] pci_rdata;
    logic [19:0] evt_pulse = '0;
    logic        cpu_irq, pci_irq;

    int checks = 0;
    int failures = 0;
    bit reported = 1'b0;

    always #10 clk = ~clk;

    irq_cause_hub dut (
        .clk(clk), .rst(rst),
        .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .pci_sel(pci_sel), .pci_wr(pci_wr), .pci_addr(pci_addr),
        .pci_wdata(pci_wdata), .pci_rdata(pci_rdata),
        .evt_pulse(evt_pulse), .cpu_irq(cpu_irq), .pci_irq(pci_irq)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // One clock cycle of stimulus from both hosts and the event sources.
    task automatic cycle(input logic cw, input logic [1:0] ca, input logic [31:0] cd,
                         input logic pw, input logic [1:0] pa, input logic [31:0] pd,
                         input logic [19:0] ev);
        @(negedge clk);
        cpu_sel = cw; cpu_wr = cw; cpu_addr = ca; cpu_wdata = cd;
        pci_sel = pw; pci_wr = pw; pci_addr = pa; pci_wdata = pd;
        evt_pulse = ev;
        @(negedge clk);
        cpu_sel = 0; cpu_wr = 0; pci_sel = 0; pci_wr = 0; evt_pulse = '0;
    endtask

    task automatic cpu_write(input logic [1:0] a, input logic [31:0] d);
        cycle(1, a, d, 0, 0, 0, '0);
    endtask

    task automatic pci_write(input logic [1:0] a, input logic [31:0] d);
        cycle(0, 0, 0, 1, a, d, '0);
    endtask

    task automatic pulse(input logic [19:0] ev);
        cycle(0, 0, 0, 0, 0, 0, ev);
    endtask

    task automatic cpu_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        cpu_sel = 1; cpu_wr = 0; cpu_addr = a;
        #2 d = cpu_rdata;
        cpu_sel = 0;
    endtask

    task automatic pci_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        pci_sel = 1; pci_wr = 0; pci_addr = a;
        #2 d = pci_rdata;
        pci_sel = 0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        cpu_read(0, d); chk("R1 cause", d, 32'h0);
        cpu_read(1, d); chk("R1 cpu mask", d, 32'h0);
        pci_read(1, d); chk("R1 pci mask", d, 32'h0);
        chk("R1 irqs", {30'b0, pci_irq, cpu_irq}, 32'h0);
    endtask

    task automatic t_event_set();
        logic [31:0] d;
        pulse(20'h00009);
        cpu_read(0, d); chk("R2 events set bits 1,4", d, 32'h00000013);
        chk("R7 summary unmasked, irqs low", {30'b0, pci_irq, cpu_irq}, 32'h0);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        cpu_write(0, 32'hFFFF_FFFD);
        pci_read(0, d); chk("R3 cpu clears bit1", d, 32'h00000011);
        pci_write(0, 32'hFFFF_FFEF);
        cpu_read(0, d); chk("R3 pci clears bit4", d, 32'h0);
        pulse(20'h80000);
        cycle(1, 0, 32'hFFFF_FFFF, 1, 0, 32'hFFFF_FFFF, '0);
        cpu_read(0, d); chk("R3 ones keep bit20", d, 32'h00100001);
        cpu_write(0, 32'hFFEF_FFFF);
        cpu_read(0, d); chk("R3 clear bit20", d, 32'h0);
    endtask

    task automatic t_cpu_doorbell();
        logic [31:0] d;
        cpu_write(0, 32'hFFDF_FFFF);
        pci_read(0, d); chk("R4 cpu sets bit21", d, 32'h00200001);
        pci_write(0, 32'hFFBF_FFFF);
        pci_read(0, d); chk("R4 pci zero does not set bit22", d, 32'h00200001);
        pci_write(0, 32'hFFDF_FFFF);
        cpu_read(0, d); chk("R4 pci clears bit21", d, 32'h0);
    endtask

    task automatic t_pci_doorbell();
        logic [31:0] d;
        pci_write(0, 32'hFBFF_FFFF);
        cpu_read(0, d); chk("R5 pci sets bit26", d, 32'h04000001);
        cpu_write(0, 32'hF7FF_FFFF);
        cpu_read(0, d); chk("R5 cpu zero does not set bit27", d, 32'h04000001);
        cpu_write(0, 32'hFBFF_FFFF);
        pci_read(0, d); chk("R5 cpu clears bit26", d, 32'h0);
    endtask

    task automatic t_set_wins();
        logic [31:0] d;
        pulse(20'h00020);
        cycle(1, 0, 32'hFFFF_FFBF, 0, 0, 0, 20'h00020);
        cpu_read(0, d); chk("R6 held bit6 survives clear", d, 32'h00000041);
        cycle(1, 0, 32'hFFFF_FEFF, 0, 0, 0, 20'h00080);
        cpu_read(0, d); chk("R6 fresh bit8 set beats clear", d, 32'h00000141);
        cpu_write(0, 32'hFFFF_FEBF);
        cpu_read(0, d); chk("R6 cleanup", d, 32'h0);
    endtask

    task automatic t_masks();
        logic [31:0] d;
        cpu_write(1, 32'hFFFF_FFFF);
        cpu_read(1, d); chk("R10 cpu mask readback", d, 32'h3FFF_FFFE);
        pci_read(1, d); chk("R10 pci mask untouched", d, 32'h0);
    endtask

    task automatic t_cpu_irq();
        logic [31:0] d;
        cpu_write(0, 32'hFFDF_FFFF);
        cpu_read(0, d); chk("R8 cpu doorbell outside cpu scope", d, 32'h00200001);
        chk("R8 cpu_irq low", {31'b0, cpu_irq}, 32'h0);
        pci_write(1, 32'h0020_0000);
        pci_read(0, d); chk("R9 pci sum from bit21", d, 32'h80200001);
        chk("R9 pci_irq high", {31'b0, pci_irq}, 32'h1);
        pci_write(0, 32'hFBFF_FFFF);
        pci_read(0, d); chk("R8 cpu sum from bit26", d, 32'hC4200001);
        chk("R8 cpu_irq high", {31'b0, cpu_irq}, 32'h1);
        cpu_write(1, 32'hFBFF_FFFF);
        cpu_read(1, d); chk("R10 mask update", d, 32'h3BFF_FFFE);
        cpu_read(0, d); chk("R8 masked bit26", d, 32'h84200001);
        chk("R8 cpu_irq masked", {31'b0, cpu_irq}, 32'h0);
        pci_write(0, 32'hFFDF_FFFF);
        cpu_write(0, 32'hFBFF_FFFF);
        cpu_read(0, d); chk("R4 R5 cleanup", d, 32'h0);
        chk("R8 R9 irqs low", {30'b0, pci_irq, cpu_irq}, 32'h0);
    endtask

    task automatic t_pci_irq();
        logic [31:0] d;
        pulse(20'h00200);
        chk("R9 pci_irq masked event", {31'b0, pci_irq}, 32'h0);
        chk("R8 cpu_irq event", {31'b0, cpu_irq}, 32'h1);
        pci_write(1, 32'h0000_0400);
        cpu_read(0, d); chk("R9 pci sum event bit10", d, 32'hC0000401);
        chk("R9 pci_irq high", {31'b0, pci_irq}, 32'h1);
        cpu_write(0, 32'hFFFF_FBFF);
        cpu_read(0, d); chk("R3 cleanup", d, 32'h0);
    endtask

    task automatic t_readonly();
        logic [31:0] d;
        cpu_write(0, 32'h3FFF_FFFE);
        pci_write(0, 32'h3FFF_FFFE);
        cpu_read(0, d); chk("R11 writes to bits 0,30,31 ignored", d, 32'h0);
    endtask

    task automatic t_dual();
        logic [31:0] d;
        pulse(20'h00006);
        cycle(1, 0, 32'hFFFF_FFFB, 1, 0, 32'hFFFF_FFF7, '0);
        cpu_read(0, d); chk("R12 both clears apply", d, 32'h0);
        cycle(1, 0, 32'hFFBF_FFFF, 1, 0, 32'hFFBF_FFFF, '0);
        pci_read(0, d); chk("R12 doorbell set beats clear", d, 32'h00400001);
        pci_write(0, 32'hFFBF_FFFF);
        pci_read(0, d); chk("R12 cleanup", d, 32'h0);
    endtask

    task automatic t_decode();
        logic [31:0] d;
        pulse(20'h00001);
        cpu_write(2, 32'h0);
        cpu_read(0, d); chk("R13 offset2 write ignored (cause)", d, 32'h40000003);
        cpu_read(1, d); chk("R13 offset2 write ignored (mask)", d, 32'h3BFF_FFFE);
        cpu_read(3, d); chk("R13 offset3 reads zero", d, 32'h0);
        @(negedge clk);
        cpu_sel = 0; cpu_wr = 1; cpu_addr = 0; cpu_wdata = 32'h0;
        @(negedge clk);
        cpu_wr = 0;
        #2 chk("R13 idle read data zero", cpu_rdata, 32'h0);
        pci_read(0, d); chk("R13 unselected write ignored", d, 32'h40000003);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_event_set();
        t_clear();
        t_cpu_doorbell();
        t_pci_doorbell();
        t_set_wins();
        t_masks();
        t_cpu_irq();
        t_pci_irq();
        t_readonly();
        t_dual();
        t_decode();
        if (!reported) begin
            reported = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        end
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!reported) begin
            reported = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%08h expected=%08h", 32'h1, 32'h0);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        end
        $finish;
    end

endmodule